// File: doc/BRIEF.md
# Brightness, Contrast and Saturation Adjuster with Output Limiting

This block adjusts one video pixel per clock in 8-bit Y, Cb and Cr form. The luminance component is multiplied by a contrast gain and then shifted by a brightness offset. Each colour difference component is first centred on zero, then scaled by a saturation gain. A second gain, held separately for Cb and for Cr, is then applied so the two components can be matched in amplitude. After processing, every component is limited to the range 1..254, which keeps codes 0 and 255 free for timing signals.

Gains are unsigned 8-bit values in which 64 stands for a gain of 1.0. Brightness is an unsigned 8-bit offset in which 128 means no change. The gain and offset values are static setup inputs and should be held steady while pixels are in flight. A pixel presented with its valid strobe comes out two clock edges later, with its own valid pulse.

Top module: `bcsAdjust`

## Requirements
- R1: While reset is low and on the first cycles after its release, before any valid input, outValid is 0 and outY, outCb and outCr are 0.
- R2: A pixel sampled with inValid high at clock edge k appears on the outputs after edge k+1, with outValid high for exactly that cycle. outValid is 0 after edge k. Back-to-back inputs give back-to-back outputs in the same order.
- R3: The luminance output is lim(rnd(inY*contrast) + brightness - 128). Here rnd(x) = floor((x+32)/64), and lim limits its argument to the range 1..254.
- R4: Each chroma output is lim(rnd(rnd((in-128)*saturation)*match) + 128). The match gain is cbMatch for Cb and crMatch for Cr. rnd uses floor, so rounding goes toward minus infinity for negative values (for example, -33 rounds to -1 and -32 rounds to 0).
- R5: Every output component delivered with outValid is between 1 and 254 inclusive, including for inputs of 0 and 255 and for large gains.
- R6: The luminance output does not depend on saturation, cbMatch or crMatch. The chroma outputs do not depend on contrast or brightness.
- R7: While no new pixel completes, outY, outCb and outCr hold their last values. Pixel inputs presented with inValid low have no effect on the outputs.
- R8: With all gains at 64 and brightness at 128, each output equals its input, limited to the range 1..254.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel strobe |
| inY | input | 8 | Input luminance |
| inCb | input | 8 | Input blue colour difference, offset binary |
| inCr | input | 8 | Input red colour difference, offset binary |
| contrast | input | 8 | Luminance gain, 64 = 1.0 |
| brightness | input | 8 | Luminance offset, 128 = none |
| saturation | input | 8 | Common chroma gain, 64 = 1.0 |
| cbMatch | input | 8 | Cb amplitude matching gain, 64 = 1.0 |
| crMatch | input | 8 | Cr amplitude matching gain, 64 = 1.0 |
| outValid | output | 1 | Output pixel strobe |
| outY | output | 8 | Adjusted luminance |
| outCb | output | 8 | Adjusted Cb |
| outCr | output | 8 | Adjusted Cr |

## Verification
A wrong valid pipeline shows up at once: outValid appears one edge too early or too late, or a pulse goes missing in a back-to-back burst. A stage register that loads without a strobe, or fails to load on one, shows the wrong pixel or a changed value at the next idle cycle. An error in rounding, centring or limiting changes an output value two edges after the pixel that exposes it. Such pixels are the ones with small negative chroma, the extremes 0 and 255, and very large or zero gains.

// File: rtl/bcsPkg.sv
package bcsPkg;

  typedef struct packed {
    logic load1;
    logic load2;
  } bcsStrobes_t;

  function automatic int limitRange(int value, int lo, int hi);
    if (value < lo) return lo;
    if (value > hi) return hi;
    return value;
  endfunction

endpackage

// File: rtl/bcsCtrl.sv
module bcsCtrl
  import bcsPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output bcsStrobes_t strb,
  output logic        outValid
);

  logic stage1Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
    end
  end

  assign strb.load1 = inValid;
  assign strb.load2 = stage1Valid;

  // R2: a pixel in gives a valid out two edges later
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);

  // R2: no input means no output two edges later
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid);

  // R2: the second stage loads exactly when output becomes valid
  assert_stage_align_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load2 |=> outValid);

endmodule

// File: rtl/bcsChromaLane.sv
module bcsChromaLane
  import bcsPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int GAIN_W  = 8,
  parameter int FRAC_W  = 6,
  parameter int OUT_MIN = 1,
  parameter int OUT_MAX = 254
) (
  input  logic              clk,
  input  logic              rstN,
  input  bcsStrobes_t       strb,
  input  logic [DATA_W-1:0] chromaIn,
  input  logic [GAIN_W-1:0] satGain,
  input  logic [GAIN_W-1:0] matchGain,
  output logic [DATA_W-1:0] chromaOut
);

  localparam int CEN_W = DATA_W + 1;
  localparam int P1_W  = CEN_W + GAIN_W + 1;
  localparam int P2_W  = P1_W + GAIN_W + 1;
  localparam int MID   = 1 << (DATA_W - 1);
  localparam int ROUND = 1 << (FRAC_W - 1);

  // stage 1: centre and apply saturation
  logic signed [CEN_W-1:0] centered;
  logic signed [P1_W-1:0]  cenExt;
  logic signed [P1_W-1:0]  satExt;
  logic signed [P1_W-1:0]  prod1;
  logic signed [P1_W-1:0]  scaled1;
  logic signed [P1_W-1:0]  stage1Val;

  assign centered = $signed({1'b0, chromaIn}) - $signed(CEN_W'(MID));
  assign cenExt   = {{(P1_W-CEN_W){centered[CEN_W-1]}}, centered};
  assign satExt   = {{(P1_W-GAIN_W){1'b0}}, satGain};
  assign prod1    = cenExt * satExt;
  assign scaled1  = (prod1 + P1_W'(ROUND)) >>> FRAC_W;

  always_ff @(posedge clk) begin
    if (!rstN)
      stage1Val <= '0;
    else if (strb.load1)
      stage1Val <= scaled1;
  end

  // stage 2: amplitude matching, re-offset and limit
  logic signed [P2_W-1:0] s1Ext;
  logic signed [P2_W-1:0] matchExt;
  logic signed [P2_W-1:0] prod2;
  logic signed [P2_W-1:0] scaled2;
  int                     recentred;
  logic [DATA_W-1:0]      limited;

  assign s1Ext    = {{(P2_W-P1_W){stage1Val[P1_W-1]}}, stage1Val};
  assign matchExt = {{(P2_W-GAIN_W){1'b0}}, matchGain};
  assign prod2    = s1Ext * matchExt;
  assign scaled2  = (prod2 + P2_W'(ROUND)) >>> FRAC_W;

  always_comb begin
    recentred = int'(scaled2) + MID;
    limited   = DATA_W'(limitRange(recentred, OUT_MIN, OUT_MAX));
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      chromaOut <= '0;
    else if (strb.load2)
      chromaOut <= limited;
  end

  // R5: every delivered chroma value is inside the legal range
  assert_chroma_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.load2 |=> (int'(chromaOut) >= OUT_MIN && int'(chromaOut) <= OUT_MAX));

  // R7: chroma holds when the output stage does not load
  assert_chroma_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load2 |=> $stable(chromaOut));

  // R4: zero saturation leaves nothing in stage 1
  assert_zero_sat_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load1 && satGain == '0) |=> (stage1Val == '0));

endmodule

// File: rtl/bcsDatapath.sv
module bcsDatapath
  import bcsPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int GAIN_W  = 8,
  parameter int FRAC_W  = 6,
  parameter int OUT_MIN = 1,
  parameter int OUT_MAX = 254
) (
  input  logic              clk,
  input  logic              rstN,
  input  bcsStrobes_t       strb,
  input  logic [DATA_W-1:0] inY,
  input  logic [DATA_W-1:0] inCb,
  input  logic [DATA_W-1:0] inCr,
  input  logic [GAIN_W-1:0] contrast,
  input  logic [DATA_W-1:0] brightness,
  input  logic [GAIN_W-1:0] saturation,
  input  logic [GAIN_W-1:0] cbMatch,
  input  logic [GAIN_W-1:0] crMatch,
  output logic [DATA_W-1:0] outY,
  output logic [DATA_W-1:0] outCb,
  output logic [DATA_W-1:0] outCr
);

  localparam int LP_W   = DATA_W + GAIN_W + 1;
  localparam int MID    = 1 << (DATA_W - 1);
  localparam int ROUND  = 1 << (FRAC_W - 1);
  localparam int LANES  = 2;

  // luminance stage 1: contrast
  logic [LP_W-1:0] prodY;
  logic [LP_W-1:0] scaledY;
  logic [LP_W-1:0] stage1Y;

  assign prodY   = {{(LP_W-DATA_W){1'b0}}, inY} * {{(LP_W-GAIN_W){1'b0}}, contrast};
  assign scaledY = (prodY + LP_W'(ROUND)) >> FRAC_W;

  always_ff @(posedge clk) begin
    if (!rstN)
      stage1Y <= '0;
    else if (strb.load1)
      stage1Y <= scaledY;
  end

  // luminance stage 2: brightness and limit
  int                lumaSum;
  logic [DATA_W-1:0] lumaLimited;

  always_comb begin
    lumaSum     = int'(stage1Y) + int'(brightness) - MID;
    lumaLimited = DATA_W'(limitRange(lumaSum, OUT_MIN, OUT_MAX));
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      outY <= '0;
    else if (strb.load2)
      outY <= lumaLimited;
  end

  // chroma lanes, one per colour difference component
  logic [DATA_W-1:0] laneIn   [LANES];
  logic [GAIN_W-1:0] laneGain [LANES];
  logic [DATA_W-1:0] laneOut  [LANES];

  assign laneIn[0]   = inCb;
  assign laneIn[1]   = inCr;
  assign laneGain[0] = cbMatch;
  assign laneGain[1] = crMatch;

  for (genvar lane = 0; lane < LANES; lane++) begin : genLane
    bcsChromaLane #(
      .DATA_W (DATA_W),
      .GAIN_W (GAIN_W),
      .FRAC_W (FRAC_W),
      .OUT_MIN(OUT_MIN),
      .OUT_MAX(OUT_MAX)
    ) laneInst (
      .clk      (clk),
      .rstN     (rstN),
      .strb     (strb),
      .chromaIn (laneIn[lane]),
      .satGain  (saturation),
      .matchGain(laneGain[lane]),
      .chromaOut(laneOut[lane])
    );
  end

  assign outCb = laneOut[0];
  assign outCr = laneOut[1];

  // R5: delivered luminance is inside the legal range
  assert_luma_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.load2 |=> (int'(outY) >= OUT_MIN && int'(outY) <= OUT_MAX));

  // R7: luminance holds when the output stage does not load
  assert_luma_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load2 |=> $stable(outY));

  // R3: zero contrast leaves nothing in the luminance stage
  assert_zero_contrast_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load1 && contrast == '0) |=> (stage1Y == '0));

endmodule

// File: rtl/bcsAdjust.sv
module bcsAdjust
  import bcsPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int GAIN_W  = 8,
  parameter int FRAC_W  = 6,
  parameter int OUT_MIN = 1,
  parameter int OUT_MAX = 254
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inY,
  input  logic [DATA_W-1:0] inCb,
  input  logic [DATA_W-1:0] inCr,
  input  logic [GAIN_W-1:0] contrast,
  input  logic [DATA_W-1:0] brightness,
  input  logic [GAIN_W-1:0] saturation,
  input  logic [GAIN_W-1:0] cbMatch,
  input  logic [GAIN_W-1:0] crMatch,
  output logic              outValid,
  output logic [DATA_W-1:0] outY,
  output logic [DATA_W-1:0] outCb,
  output logic [DATA_W-1:0] outCr
);

  bcsStrobes_t strb;

  bcsCtrl ctrlInst (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strb    (strb),
    .outValid(outValid)
  );

  bcsDatapath #(
    .DATA_W (DATA_W),
    .GAIN_W (GAIN_W),
    .FRAC_W (FRAC_W),
    .OUT_MIN(OUT_MIN),
    .OUT_MAX(OUT_MAX)
  ) dataInst (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .inY       (inY),
    .inCb      (inCb),
    .inCr      (inCr),
    .contrast  (contrast),
    .brightness(brightness),
    .saturation(saturation),
    .cbMatch   (cbMatch),
    .crMatch   (crMatch),
    .outY      (outY),
    .outCb     (outCb),
    .outCr     (outCr)
  );

endmodule

// File: tb/bcsAdjust_test.sv
`timescale 1ns/1ps
module bcsAdjust_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inY = '0, inCb = '0, inCr = '0;
  logic [7:0] contrast = 8'd64, brightness = 8'd128, saturation = 8'd64;
  logic [7:0] cbMatch = 8'd64, crMatch = 8'd64;
  logic       outValid;
  logic [7:0] outY, outCb, outCr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int pY  [0:7];
  int pCb [0:7];
  int pCr [0:7];
  int lastY, lastCb, lastCr;

  always #2 clk = ~clk;

  bcsAdjust uut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inY(inY), .inCb(inCb), .inCr(inCr),
    .contrast(contrast), .brightness(brightness), .saturation(saturation),
    .cbMatch(cbMatch), .crMatch(crMatch),
    .outValid(outValid), .outY(outY), .outCb(outCb), .outCr(outCr)
  );

  function automatic int rnd(int x);
    return (x + 32) >>> 6;
  endfunction

  function automatic int lim(int v);
    if (v < 1) return 1;
    if (v > 254) return 254;
    return v;
  endfunction

  function automatic int expY(int y);
    return lim(rnd(y * int'(contrast)) + int'(brightness) - 128);
  endfunction

  function automatic int expC(int c, int g);
    return lim(rnd(rnd((c - 128) * int'(saturation)) * g) + 128);
  endfunction

  task automatic check(string req, string what, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic setRegs(int c, int b, int s, int gb, int gr);
    @(negedge clk);
    contrast = 8'(c); brightness = 8'(b); saturation = 8'(s);
    cbMatch = 8'(gb); crMatch = 8'(gr);
  endtask

  task automatic checkPixel(string req, int i);
    lastY  = expY(pY[i]);
    lastCb = expC(pCb[i], int'(cbMatch));
    lastCr = expC(pCr[i], int'(crMatch));
    check("R2", "outValid", int'(outValid), 1);
    check(req, "outY",  int'(outY),  lastY);
    check(req, "outCb", int'(outCb), lastCb);
    check(req, "outCr", int'(outCr), lastCr);
  endtask

  // drives pixels back to back and checks each two edges later
  task automatic runStream(string req, int n);
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      if (i == 1) check("R2", "outValid before output", int'(outValid), 0);
      if (i >= 2) checkPixel(req, i - 2);
      if (i < n) begin
        inValid = 1'b1; inY = 8'(pY[i]); inCb = 8'(pCb[i]); inCr = 8'(pCr[i]);
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic setPix(int i, int y, int cb, int cr);
    pY[i] = y; pCb[i] = cb; pCr[i] = cr;
  endtask

  task automatic testReset;
    @(negedge clk);
    check("R1", "outValid in reset", int'(outValid), 0);
    check("R1", "outY in reset", int'(outY), 0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", "outValid after reset", int'(outValid), 0);
    check("R1", "outCb after reset", int'(outCb), 0);
    check("R1", "outCr after reset", int'(outCr), 0);
  endtask

  task automatic testUnity;
    setRegs(64, 128, 64, 64, 64);
    setPix(0, 16, 128, 128);
    setPix(1, 100, 50, 200);
    setPix(2, 0, 0, 255);
    setPix(3, 255, 255, 0);
    setPix(4, 1, 254, 1);
    runStream("R8", 5);
  endtask

  task automatic testLuma;
    setRegs(96, 150, 64, 64, 64);
    setPix(0, 80, 128, 128);
    setPix(1, 200, 128, 128);
    setPix(2, 3, 128, 128);
    runStream("R3", 3);
    setRegs(32, 60, 64, 64, 64);
    setPix(0, 10, 128, 128);
    setPix(1, 255, 128, 128);
    setPix(2, 137, 128, 128);
    runStream("R3", 3);
  endtask

  task automatic testChroma;
    setRegs(64, 128, 128, 80, 40);
    setPix(0, 50, 60, 60);
    setPix(1, 50, 200, 200);
    setPix(2, 50, 127, 129);
    runStream("R4", 3);
    setRegs(64, 128, 32, 64, 64);
    setPix(0, 50, 127, 126);
    runStream("R4", 1);
    setRegs(64, 128, 33, 64, 64);
    setPix(0, 50, 127, 129);
    runStream("R4", 1);
    setRegs(64, 128, 0, 255, 255);
    setPix(0, 50, 0, 255);
    runStream("R4", 1);
  endtask

  task automatic testLimits;
    setRegs(255, 255, 255, 255, 255);
    setPix(0, 255, 0, 255);
    setPix(1, 0, 255, 0);
    setPix(2, 128, 120, 136);
    runStream("R5", 3);
    setRegs(255, 0, 255, 255, 255);
    setPix(0, 20, 128, 128);
    runStream("R5", 1);
  endtask

  task automatic testIndependence;
    int y0, cb0;
    setRegs(80, 140, 64, 64, 64);
    setPix(0, 90, 70, 190);
    runStream("R6", 1);
    y0 = int'(outY);
    setRegs(80, 140, 200, 10, 250);
    runStream("R6", 1);
    check("R6", "outY vs chroma gains", int'(outY), y0);
    cb0 = int'(outCb);
    setRegs(10, 30, 200, 10, 250);
    runStream("R6", 1);
    check("R6", "outCb vs luma regs", int'(outCb), cb0);
  endtask

  task automatic testHold;
    setRegs(70, 120, 90, 60, 70);
    setPix(0, 140, 90, 170);
    runStream("R7", 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      inValid = 1'b0; inY = 8'(k * 37 + 5); inCb = 8'(k * 91); inCr = 8'(250 - k);
      check("R7", "outValid idle", int'(outValid), 0);
      check("R7", "outY held", int'(outY), lastY);
      check("R7", "outCb held", int'(outCb), lastCb);
      check("R7", "outCr held", int'(outCr), lastCr);
    end
  endtask

  initial begin
    testReset();
    testUnity();
    testLuma();
    testChroma();
    testLimits();
    testIndependence();
    testHold();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule